// File: doc/BRIEF.md
# Multi-phase stage enable sequencer

This block splits each I/O clock period into a short train of non-overlapping phases. A cascade of lookup stages can then evaluate one stage after another inside a single I/O cycle. The block runs on a fast clock at nine times the I/O rate in the full-length mode. It watches the I/O clock as a sampled level, and each rising edge it detects starts a fresh train at phase 0. It produces a one-hot phase strobe and one enable per stage. A downstream clock gate turns each stage enable into that stage's clock.

A mode input sets the length of the cascade. The whole chain of `STAGES` stages uses `STAGES+1` phases. Two half-length chains run side by side in `STAGES/2+1` phases, and four quarter-length chains in `STAGES/4+1` phases. In every mode the last phase of the train drives no stage. That idle slot gives the I/O registers setup and hold margin around the first and last stages. When several chains run side by side, the same stage position in each chain is enabled in the same phase. If no new I/O edge arrives, the train restarts by itself after its last phase. A new mode is taken only when a train starts.

Top module: `mps_stage_sequencer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first I/O clock rising edge is detected, every bit of `phase_strobe` and `stage_en` is 0.
- R2: An I/O rising edge is detected on the `clk` edge that samples `io_clk` high after the previous `clk` edge sampled it low. `phase_strobe` equals 1 (bit 0, phase 0) starting one `clk` cycle after that edge.
- R3: Once running, `phase_strobe` moves from bit k to bit k+1 on every `clk` cycle. It returns to bit 0 after the last phase of the mode with no I/O edge needed. The last phase is bit G, where G = STAGES >> code (bit 8, 4 and 2 for codes 0, 1 and 2 with STAGES=8).
- R4: `phase_strobe` has at most one bit set in every cycle.
- R5: Stage s is enabled exactly in phase (s mod G). In phase G, the spare phase, all of `stage_en` is 0. Stage 0 is enabled in exactly the cycles where phase 0 is shown.
- R6: In code 1 the stages s and s+4 are enabled together: 8'h11, 8'h22, 8'h44, 8'h88 in phases 0 to 3. In code 2 the even stages are enabled in phase 0 (8'h55) and the odd stages in phase 1 (8'hAA).
- R7: An I/O rising edge detected partway through a train restarts it. Phase 0 is shown one cycle after the detecting edge, whatever phase was current.
- R8: A change of `mode_sel` takes effect only when a new train starts, either at the wrap or at a detected I/O edge. The train already running completes its phases in its old mode.
- R9: A `mode_sel` value of MODES or more (code 3 with MODES=3) selects the full-length mode, code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock, 9x the I/O rate in full-length mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk | input | 1 | I/O clock level, sampled on `clk` |
| mode_sel | input | $clog2(MODES) | Cascade length code: 0 full, 1 halves, 2 quarters |
| phase_strobe | output | STAGES+1 | One-hot current phase; bit STAGES marks the spare phase in full mode |
| stage_en | output | STAGES | Per-stage evaluate enable, one bit per lookup stage |

## Verification
The bench builds the block with its defaults of eight stages and three mode codes. This reaches all three train lengths (9, 5 and 3 phases), the replicated enable patterns of the split cascades, and the unsupported code 3 that falls back to full length. Directed steps cover the wrap without an edge, mode changes made partway through a train, and a realigning edge at phase 4. Thousands of random cycles follow, with I/O periods both shorter and longer than the train, and each one is compared against a cycle model held in the bench.

// File: rtl/mps_pkg.sv
package mps_pkg;

    // Number of stages in one chain for a given mode code.
    function automatic int unsigned chain_len(input int unsigned stages,
                                              input int unsigned code);
        return stages >> code;
    endfunction

endpackage

// File: rtl/mps_phase_ctr.sv
module mps_phase_ctr #(
    parameter int STAGES = 8,
    parameter int MODES  = 3,
    parameter int CNT_W  = $clog2(STAGES + 1),
    parameter int CODE_W = $clog2(MODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_clk,
    input  logic [CODE_W-1:0] mode_sel,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CODE_W-1:0] code_o,
    output logic              run_o
);
    import mps_pkg::*;

    typedef struct packed {
        logic              io;
        logic              run;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    logic              rise;
    logic              wrap;
    logic [CODE_W-1:0] code_in;
    logic [CNT_W-1:0]  spare_ph;

    always_comb begin
        rise     = io_clk & ~st_q.io;
        spare_ph = CNT_W'(chain_len(STAGES, int'(st_q.code)));
        wrap     = st_q.run && (st_q.cnt == spare_ph);
        code_in  = (int'(mode_sel) < MODES) ? mode_sel : '0;

        st_d    = st_q;
        st_d.io = io_clk;
        if (rise || wrap) begin
            st_d.cnt  = '0;
            st_d.code = code_in;
            st_d.run  = 1'b1;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign code_o = st_q.code;
    assign run_o  = st_q.run;

    // R7
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (st_q.run && st_q.cnt == '0));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= spare_ph);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt != '0) |-> $stable(st_q.code));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> st_q.cnt == '0);

endmodule

// File: rtl/mps_phase_decode.sv
module mps_phase_decode #(
    parameter int STAGES = 8,
    parameter int CNT_W  = $clog2(STAGES + 1),
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              run_i,
    output logic [STAGES:0]   strobe_o,
    output logic [STAGES-1:0] stage_o
);
    import mps_pkg::*;

    typedef struct packed {
        logic [STAGES:0]   strobe;
        logic [STAGES-1:0] stage;
    } dec_t;

    dec_t st_d, st_q;

    logic [CNT_W-1:0]  pos_mask;
    logic [STAGES:0]   strobe_hit;
    logic [STAGES-1:0] stage_hit;

    assign pos_mask = CNT_W'(chain_len(STAGES, int'(code_i)) - 1);

    for (genvar p = 0; p <= STAGES; p++) begin : g_phase
        assign strobe_hit[p] = run_i && (cnt_i == CNT_W'(p));
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign stage_hit[s] = run_i && ((CNT_W'(s) & pos_mask) == cnt_i);
    end

    always_comb begin
        st_d        = st_q;
        st_d.strobe = strobe_hit;
        st_d.stage  = stage_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;
    assign stage_o  = st_q.stage;

    // R4
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.strobe));

    // R1
    quiet_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.strobe == '0) |-> (st_q.stage == '0));

    // R5
    spare_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe[STAGES] |-> (st_q.stage == '0));

endmodule

// File: rtl/mps_stage_sequencer.sv
module mps_stage_sequencer #(
    parameter int STAGES = 8,
    parameter int MODES  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_clk,
    input  logic [$clog2(MODES)-1:0]  mode_sel,
    output logic [STAGES:0]           phase_strobe,
    output logic [STAGES-1:0]         stage_en
);
    localparam int PHASES = STAGES + 1;
    localparam int CNT_W  = $clog2(PHASES);
    localparam int CODE_W = $clog2(MODES);

    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] code;
    logic              run;

    mps_phase_ctr #(
        .STAGES (STAGES),
        .MODES  (MODES),
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_clk   (io_clk),
        .mode_sel (mode_sel),
        .cnt_o    (cnt),
        .code_o   (code),
        .run_o    (run)
    );

    mps_phase_decode #(
        .STAGES (STAGES),
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt),
        .code_i   (code),
        .run_i    (run),
        .strobe_o (phase_strobe),
        .stage_o  (stage_en)
    );

    // R5
    stage0_phase0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en[0] == phase_strobe[0]);

    // R3
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase_strobe == '0) |=> (phase_strobe != '0));

endmodule

// File: tb/sim_mps_stage_sequencer.sv
module sim_mps_stage_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_clk = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [8:0] phase_strobe;
    logic [7:0] stage_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mps_stage_sequencer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_clk       (io_clk),
        .mode_sel     (mode_sel),
        .phase_strobe (phase_strobe),
        .stage_en     (stage_en)
    );

    function automatic int f_norm(input logic [1:0] m);
        return (m < 2'd3) ? int'(m) : 0;
    endfunction

    function automatic int f_grp(input int code);
        return 8 >> code;
    endfunction

    function automatic logic [7:0] f_stage(input int cnt, input int code);
        logic [7:0] r;
        int g;
        g = f_grp(code);
        for (int s = 0; s < 8; s++) r[s] = (cnt < g) && ((s % g) == cnt);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model built from the requirements.
    int m_cnt = 0;
    int m_code = 0;
    bit m_run = 1'b0;
    bit m_io = 1'b0;
    logic [8:0] e_strobe = '0;
    logic [7:0] e_stage = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_code = 0; m_run = 1'b0; m_io = 1'b0;
            e_strobe = '0; e_stage = '0;
        end else begin
            e_strobe = m_run ? (9'd1 << m_cnt) : 9'd0;
            e_stage  = m_run ? f_stage(m_cnt, m_code) : 8'd0;
            if ((io_clk && !m_io) || (m_run && m_cnt == f_grp(m_code))) begin
                m_cnt = 0; m_code = f_norm(mode_sel); m_run = 1'b1;
            end else if (m_run) begin
                m_cnt++;
            end
            m_io = io_clk;
        end
    end

    // Continuous comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(phase_strobe == e_strobe, "R3 strobe vs model", 32'(phase_strobe), 32'(e_strobe));
            chk(stage_en == e_stage, "R5 stage vs model", 32'(stage_en), 32'(e_stage));
            chk($countones(phase_strobe) <= 1, "R4 one-hot", 32'(phase_strobe), 32'd1);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_out(input logic [8:0] es, input logic [7:0] ee, input string tag);
        chk(phase_strobe == es, tag, 32'(phase_strobe), 32'(es));
        chk(stage_en == ee, tag, 32'(stage_en), 32'(ee));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) step();
        expect_out(9'h000, 8'h00, "R1 in reset");
        rst_n = 1'b1;
        repeat (4) step();
        expect_out(9'h000, 8'h00, "R1 no edge yet");

        // R2: detection latency
        io_clk = 1'b1;
        step();
        expect_out(9'h000, 8'h00, "R2 before phase 0");
        step();
        expect_out(9'h001, 8'h01, "R2 phase 0");
        for (int k = 1; k <= 8; k++) begin
            step();
            expect_out(9'd1 << k, (k < 8) ? (8'd1 << k) : 8'h00, "R3 R5 full train");
        end
        step();
        expect_out(9'h001, 8'h01, "R3 wrap without edge");

        // R8: switch to halves mid-train
        mode_sel = 2'd1;
        for (int k = 1; k <= 8; k++) begin
            step();
            chk(phase_strobe == (9'd1 << k), "R8 old mode completes", 32'(phase_strobe), 32'(9'd1 << k));
        end
        step(); expect_out(9'h001, 8'h11, "R6 halves p0");
        step(); expect_out(9'h002, 8'h22, "R6 halves p1");
        step(); expect_out(9'h004, 8'h44, "R6 halves p2");
        step(); expect_out(9'h008, 8'h88, "R6 halves p3");
        step(); expect_out(9'h010, 8'h00, "R5 halves spare");
        step(); expect_out(9'h001, 8'h11, "R3 halves wrap");

        mode_sel = 2'd2;
        for (int k = 1; k <= 4; k++) begin
            step();
            chk(phase_strobe == (9'd1 << k), "R8 halves completes", 32'(phase_strobe), 32'(9'd1 << k));
        end
        step(); expect_out(9'h001, 8'h55, "R6 quarters p0");
        step(); expect_out(9'h002, 8'hAA, "R6 quarters p1");
        step(); expect_out(9'h004, 8'h00, "R5 quarters spare");
        step(); expect_out(9'h001, 8'h55, "R3 quarters wrap");

        // R9: unsupported code falls back to full length
        mode_sel = 2'd3;
        step(); chk(phase_strobe == 9'h002, "R8 quarters completes", 32'(phase_strobe), 32'h002);
        step(); chk(phase_strobe == 9'h004, "R8 quarters completes", 32'(phase_strobe), 32'h004);
        step(); expect_out(9'h001, 8'h01, "R9 code 3 p0");
        step(); expect_out(9'h002, 8'h02, "R9 code 3 p1");
        step(); expect_out(9'h004, 8'h04, "R9 code 3 p2");
        step(); expect_out(9'h008, 8'h08, "R9 code 3 p3");

        // R7: realign mid-train
        io_clk = 1'b0;
        step(); expect_out(9'h010, 8'h10, "R7 before realign");
        io_clk = 1'b1;
        step(); expect_out(9'h020, 8'h20, "R7 edge in flight");
        step(); expect_out(9'h001, 8'h01, "R7 realigned p0");
        step(); expect_out(9'h002, 8'h02, "R7 continues p1");

        // Random segments: mode and I/O period mixed
        for (int seg = 0; seg < 120; seg++) begin
            int per;
            int reps;
            mode_sel = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0:       per = f_grp(f_norm(mode_sel)) + 1;
                1:       per = $urandom_range(2, 5);
                default: per = $urandom_range(6, 14);
            endcase
            reps = $urandom_range(1, 4);
            for (int r = 0; r < reps; r++) begin
                for (int c = 0; c < per; c++) begin
                    io_clk = (c < (per + 1) / 2);
                    if ($urandom_range(0, 15) == 0) mode_sel = 2'($urandom_range(0, 3));
                    step();
                end
            end
        end
        repeat (3) step();
        finish_run();
    end
endmodule